// File: doc/BRIEF.md
# Cartridge Configuration Register Window

This block sits on a cartridge-side CPU bus and serves two address windows. The first is a bank of sixteen 8-bit configuration registers. All sixteen sit at the same 16-bit offset, and the register number comes from the bank byte, not from the low address bits. The second is a paged byte-wide SRAM. It is reached through a 4 KiB window in each of eight consecutive banks. Read data is returned one cycle after the read strobe. Any read that matches neither window returns zero.

Downstream mapping logic receives the live register values and a single-cycle commit pulse. The pulse tells the mapper to rebuild its address map. It fires on one qualified write to the commit register. It is also asserted out of reset, so the mapper starts from the default register values. The SRAM is held in an internal behavioural array. To keep elaboration small, the array stores only the low `OFS_W` bits of the in-page offset.

Top module: `cart_cfg_window`

## Requirements
- R1: While reset is asserted, and after it until the first write, registers 0x07 and 0x08 read 0x80 on `regs_o` and every other register reads 0x00. Register n occupies `regs_o[8n+7:8n]`.
- R2: A write strobe with `addr_i[23:20]`=0 and `addr_i[15:0]`=0x5000 stores `wdata_i` into register `addr_i[19:16]`. The new value appears on `regs_o` after that clock edge.
- R3: A read strobe at a register address puts that register's stored value on `rdata_o` during the following cycle.
- R4: An access whose low 16 bits differ from 0x5000, or whose bank has a nonzero upper nibble, neither writes a register nor returns register data.
- R5: An SRAM access decodes when `addr_i[23:19]`=5'b00010 and `addr_i[15:12]`=4'h5. Page `addr_i[18:16]` and offset `addr_i[11:0]` pick the byte, so each of the eight pages holds separate data.
- R6: After an SRAM read strobe, the addressed byte appears on `rdata_o` during the following cycle. An SRAM write takes effect at the strobe's clock edge.
- R7: The stored SRAM offset is `addr_i[OFS_W-1:0]`, with OFS_W defaulting to 8. Offsets that differ only in bits above that width address the same byte.
- R8: A write to register 0x0E with `wdata_i[7]`=1 raises `commit_o` for exactly the next cycle.
- R9: A write to register 0x0E with bit 7 clear stores the value without raising `commit_o`. A bit-7-set write to any other register does not raise `commit_o` either.
- R10: `commit_o` is high while reset is asserted and stays high until the first rising clock edge after release.
- R11: `rdata_o` is 0x00 in every cycle that does not follow a read strobe to a decoded window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 24 | CPU address, bank in [23:16] |
| rd_i | input | 1 | Read strobe, one cycle per access |
| wr_i | input | 1 | Write strobe, one cycle per access |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, valid the cycle after the read strobe |
| regs_o | output | 128 | All configuration registers, register n at [8n+7:8n] |
| commit_o | output | 1 | Map-rebuild pulse |

## Verification
Every result is due exactly one clock edge after its strobe. This covers register and SRAM updates, the commit pulse, and read data. The bench drives each strobe at the falling edge and samples 1 ns after the next rising edge, which lands inside that one-cycle result window. The reset-time commit is checked twice after release: once before the first rising edge, where it must still be high, and once after it, where it must have dropped. Register and SRAM contents are observed only through `regs_o` and a later read strobe.

// File: rtl/cart_cfg_pkg.sv
`timescale 1ns/1ps
package cart_cfg_pkg;
  localparam int ADDR_W     = 24;
  localparam int DATA_W     = 8;
  localparam int NUM_REGS   = 16;
  localparam int IDX_W      = $clog2(NUM_REGS);
  localparam int PAGE_W     = 3;
  localparam int PAGE_OFS_W = 12;
  localparam logic [IDX_W-1:0] COMMIT_IDX = IDX_W'(14);

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_REG  = 2'd1,
    SEL_SRAM = 2'd2
  } rd_sel_e;

  function automatic logic [DATA_W-1:0] reg_default(input int idx);
    return (idx == 7 || idx == 8) ? DATA_W'(8'h80) : '0;
  endfunction
endpackage

// File: rtl/cfg_addr_dec.sv
`timescale 1ns/1ps
module cfg_addr_dec
  import cart_cfg_pkg::*;
#(
  parameter int OFS_W = 8
) (
  input  logic [ADDR_W-1:0]       addr_i,
  output logic                    reg_hit_o,
  output logic                    sram_hit_o,
  output logic [IDX_W-1:0]        reg_idx_o,
  output logic [PAGE_W+OFS_W-1:0] sram_addr_o
);
  localparam int MEM_AW = PAGE_W + OFS_W;

  logic [7:0] bank;
  assign bank = addr_i[23:16];

  // registers: banks 0x00-0x0F at offset 0x5000 exactly
  assign reg_hit_o  = (bank[7:4] == 4'h0) && (addr_i[15:0] == 16'h5000);
  // SRAM: banks 0x10-0x17, offsets 0x5000-0x5FFF
  assign sram_hit_o = (bank[7:3] == 5'b00010) && (addr_i[15:12] == 4'h5);
  assign reg_idx_o  = bank[IDX_W-1:0];

  // page in upper bits, offset truncated to the modelled width
  assign sram_addr_o = MEM_AW'({bank[PAGE_W-1:0], addr_i[OFS_W-1:0]});
endmodule

// File: rtl/cfg_reg_file.sv
`timescale 1ns/1ps
module cfg_reg_file
  import cart_cfg_pkg::*;
(
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         wr_en_i,
  input  logic [IDX_W-1:0]             idx_i,
  input  logic [DATA_W-1:0]            wdata_i,
  output logic [DATA_W-1:0]            rd_data_o,
  output logic [NUM_REGS*DATA_W-1:0]   regs_o
);
  logic [DATA_W-1:0] regs_q [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        regs_q[g] <= reg_default(g);
      end else if (wr_en_i && (idx_i == IDX_W'(g))) begin
        regs_q[g] <= wdata_i;
      end
    end
    assign regs_o[g*DATA_W +: DATA_W] = regs_q[g];
  end

  assign rd_data_o = regs_q[idx_i];

  // R2
  reg_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> regs_o[$past(idx_i)*DATA_W +: DATA_W] == $past(wdata_i));

  // R4
  reg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(regs_o));
endmodule

// File: rtl/cfg_sram.sv
`timescale 1ns/1ps
module cfg_sram
  import cart_cfg_pkg::*;
#(
  parameter int AW = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << AW;

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [DATA_W-1:0] rdata_q;

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem_q[addr_i] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_q <= '0;
    else if (rd_en_i) rdata_q <= mem_q[addr_i];
  end

  assign rdata_o = rdata_q;

  // R6
  sram_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> mem_q[$past(addr_i)] == $past(wdata_i));
endmodule

// File: rtl/cart_cfg_window.sv
`timescale 1ns/1ps
module cart_cfg_window
  import cart_cfg_pkg::*;
#(
  parameter int OFS_W = 8
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [23:0]                addr_i,
  input  logic                       rd_i,
  input  logic                       wr_i,
  input  logic [7:0]                 wdata_i,
  output logic [7:0]                 rdata_o,
  output logic [127:0]               regs_o,
  output logic                       commit_o
);
  localparam int MEM_AW = PAGE_W + OFS_W;

  logic              reg_hit, sram_hit;
  logic [IDX_W-1:0]  reg_idx;
  logic [MEM_AW-1:0] sram_addr;
  logic [DATA_W-1:0] reg_rd_data, sram_rd_data;
  logic [DATA_W-1:0] reg_rd_q;
  logic              commit_wr, commit_q;
  rd_sel_e           sel_q, sel_d;

  cfg_addr_dec #(.OFS_W(OFS_W)) u_dec (
    .addr_i      (addr_i),
    .reg_hit_o   (reg_hit),
    .sram_hit_o  (sram_hit),
    .reg_idx_o   (reg_idx),
    .sram_addr_o (sram_addr)
  );

  cfg_reg_file u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_i && reg_hit),
    .idx_i     (reg_idx),
    .wdata_i   (wdata_i),
    .rd_data_o (reg_rd_data),
    .regs_o    (regs_o)
  );

  cfg_sram #(.AW(MEM_AW)) u_sram (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (wr_i && sram_hit),
    .rd_en_i (rd_i && sram_hit),
    .addr_i  (sram_addr),
    .wdata_i (wdata_i),
    .rdata_o (sram_rd_data)
  );

  always_comb begin
    sel_d = SEL_NONE;
    if (rd_i && reg_hit)       sel_d = SEL_REG;
    else if (rd_i && sram_hit) sel_d = SEL_SRAM;
  end

  assign commit_wr = wr_i && reg_hit && (reg_idx == COMMIT_IDX) && wdata_i[7];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q    <= SEL_NONE;
      reg_rd_q <= '0;
      commit_q <= 1'b1;  // power-on commit, held until first edge
    end else begin
      sel_q    <= sel_d;
      commit_q <= commit_wr;
      if (sel_d == SEL_REG) reg_rd_q <= reg_rd_data;
    end
  end

  always_comb begin
    unique case (sel_q)
      SEL_REG:  rdata_o = reg_rd_q;
      SEL_SRAM: rdata_o = sram_rd_data;
      default:  rdata_o = '0;
    endcase
  end

  assign commit_o = commit_q;

  // R8
  commit_fire_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_wr |=> commit_o);

  // R9
  commit_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit_wr |=> !commit_o);

  // R11
  unmapped_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_i && (reg_hit || sram_hit)) |=> rdata_o == '0);

  // R3
  reg_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && reg_hit && !wr_i) |=> rdata_o == $past(reg_rd_data));
endmodule

// File: tb/cart_cfg_window_tb_top.sv
`timescale 1ns/1ps
module cart_cfg_window_tb_top;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic [23:0]  addr_i = '0;
  logic         rd_i = 1'b0;
  logic         wr_i = 1'b0;
  logic [7:0]   wdata_i = '0;
  logic [7:0]   rdata_o;
  logic [127:0] regs_o;
  logic         commit_o;

  int n_vec  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #5 clk_i = ~clk_i;

  cart_cfg_window dut_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .addr_i   (addr_i),
    .rd_i     (rd_i),
    .wr_i     (wr_i),
    .wdata_i  (wdata_i),
    .rdata_o  (rdata_o),
    .regs_o   (regs_o),
    .commit_o (commit_o)
  );

  // {wr, rd, addr, wdata, exp_rdata, exp_commit}
  localparam int NV = 20;
  localparam logic [42:0] VEC [NV] = '{
    {1'b0, 1'b1, 24'h075000, 8'h00, 8'h80, 1'b0},  // R3 R1
    {1'b0, 1'b1, 24'h085000, 8'h00, 8'h80, 1'b0},  // R3 R1
    {1'b1, 1'b0, 24'h035000, 8'h5A, 8'h00, 1'b0},  // R2
    {1'b0, 1'b1, 24'h035000, 8'h00, 8'h5A, 1'b0},  // R3
    {1'b0, 1'b1, 24'h835000, 8'h00, 8'h00, 1'b0},  // R4 upper nibble
    {1'b0, 1'b1, 24'h035001, 8'h00, 8'h00, 1'b0},  // R4 low bits
    {1'b1, 1'b0, 24'h035001, 8'hFF, 8'h00, 1'b0},  // R4
    {1'b0, 1'b1, 24'h035000, 8'h00, 8'h5A, 1'b0},  // R4 unchanged
    {1'b1, 1'b0, 24'h0E5000, 8'h01, 8'h00, 1'b0},  // R9 bit7 clear
    {1'b0, 1'b1, 24'h0E5000, 8'h00, 8'h01, 1'b0},  // R9 stored
    {1'b1, 1'b0, 24'h0E5000, 8'h81, 8'h00, 1'b1},  // R8
    {1'b0, 1'b1, 24'h0E5000, 8'h00, 8'h81, 1'b0},  // R8 single cycle
    {1'b1, 1'b0, 24'h0D5000, 8'h80, 8'h00, 1'b0},  // R9 other reg
    {1'b1, 1'b0, 24'h125123, 8'h3C, 8'h00, 1'b0},  // R5
    {1'b1, 1'b0, 24'h115123, 8'hC3, 8'h00, 1'b0},  // R5
    {1'b0, 1'b1, 24'h125123, 8'h00, 8'h3C, 1'b0},  // R6 R5
    {1'b0, 1'b1, 24'h185123, 8'h00, 8'h00, 1'b0},  // R11 bank 0x18
    {1'b0, 1'b1, 24'h124123, 8'h00, 8'h00, 1'b0},  // R11 offset 0x4xxx
    {1'b1, 1'b0, 24'h1E5000, 8'h77, 8'h00, 1'b0},  // R4 bank 0x1E
    {1'b0, 1'b1, 24'h0E5000, 8'h00, 8'h81, 1'b0}   // R4 reg 0x0E kept
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // drive at falling edge, sample 1 ns after the next rising edge
  task automatic step(input logic w, input logic r, input logic [23:0] a,
                      input logic [7:0] d);
    @(negedge clk_i);
    wr_i = w; rd_i = r; addr_i = a; wdata_i = d;
    @(posedge clk_i);
    #1;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual 0x0 expected 0x1");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1;
    for (int i = 0; i < 16; i++) begin
      // R1
      check(regs_o[i*8 +: 8] == ((i == 7 || i == 8) ? 8'h80 : 8'h00), "R1",
            regs_o[i*8 +: 8], (i == 7 || i == 8) ? 8'h80 : 8'h00);
    end
    check(commit_o == 1'b1, "R10 in reset", commit_o, 1);
    @(negedge clk_i);
    rst_ni = 1'b1;
    #1;
    check(commit_o == 1'b1, "R10 before edge", commit_o, 1);
    @(posedge clk_i);
    #1;
    check(commit_o == 1'b0, "R10 after edge", commit_o, 0);
    check(rdata_o == 8'h00, "R11 idle", rdata_o, 0);

    for (int v = 0; v < NV; v++) begin
      step(VEC[v][42], VEC[v][41], VEC[v][40:17], VEC[v][16:9]);
      check(rdata_o == VEC[v][8:1], $sformatf("vec %0d rdata", v), rdata_o, VEC[v][8:1]);
      check(commit_o == VEC[v][0], $sformatf("vec %0d commit R8/R9", v), commit_o, VEC[v][0]);
    end

    // R2 aliasing across all banks
    for (int i = 0; i < 16; i++) begin
      logic [7:0] d;
      d = 8'(i * 16 + (15 - i));
      step(1'b1, 1'b0, {4'h0, 4'(i), 16'h5000}, d);
      check(regs_o[i*8 +: 8] == d, "R2 regs_o", regs_o[i*8 +: 8], d);
      check(commit_o == (i == 14 && d[7]), "R8 sweep", commit_o, (i == 14 && d[7]));
    end
    for (int i = 0; i < 16; i++) begin
      logic [7:0] d;
      d = 8'(i * 16 + (15 - i));
      step(1'b0, 1'b1, {4'h0, 4'(i), 16'h5000}, 8'h00);
      check(rdata_o == d, "R3 sweep", rdata_o, d);
    end

    // R5 page separation
    for (int p = 0; p < 8; p++) begin
      step(1'b1, 1'b0, {5'b00010, 3'(p), 16'h5042}, 8'(8'hA0 + p));
    end
    for (int p = 0; p < 8; p++) begin
      step(1'b0, 1'b1, {5'b00010, 3'(p), 16'h5042}, 8'h00);
      check(rdata_o == 8'(8'hA0 + p), "R5 page", rdata_o, 8'hA0 + p);
    end
    step(1'b0, 1'b0, 24'h105042, 8'h00);
    check(rdata_o == 8'h00, "R11 no strobe", rdata_o, 0);

    // R7 alias above modelled offset width
    step(1'b1, 1'b0, 24'h105142, 8'h11);
    step(1'b0, 1'b1, 24'h105042, 8'h00);
    check(rdata_o == 8'h11, "R7 alias", rdata_o, 8'h11);
    step(1'b0, 1'b1, 24'h115042, 8'h00);
    check(rdata_o == 8'hA1, "R7 other page intact", rdata_o, 8'hA1);

    step(1'b0, 1'b0, 24'h000000, 8'h00);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end
endmodule